// File: doc/BRIEF.md
# Staircase Level Generator with Selective Harmonic Elimination

This block produces the switching commands for one phase of a four-cell cascaded H-bridge inverter that runs at the fundamental frequency. A 16-bit phase accumulator advances by a frequency word on every clock. The current phase is folded onto the first quarter of the wave and compared with four stored switching angles. The number of angles that the folded phase has reached sets how many cells conduct. This gives a nine-step staircase that runs from -4 to +4.

The four angles are precomputed so that the staircase cancels chosen low-order harmonics while the fundamental keeps its amplitude. The hardware does not solve for them. A small write port lets new angles be loaded into a pending table. The pending table is copied into the active table only when the accumulator wraps, so one period never mixes two angle sets. A write that would break the strictly ascending order of the angles is refused, and the refusal is reported.

Top module: `she_staircase`

## Requirements
- R1: After reset the level is 0, no cell conducts, the refusal flag is low and the phase is 0.
- R2: The phase advances by `freq_word` modulo 2^16 on every clock; a full turn is 65536 units and the angles use the same units.
- R3: Let p be the phase, q = p mod 32768 and f = q when q < 16384, else 32768 - q. The target level is the number of active angles a with f >= a. This count is positive for p < 32768 and negated otherwise.
- R4: The level moves one step per clock toward the target computed from the phase held before that clock edge, and it never changes by more than one step.
- R5: When the phase is exactly 0 or exactly 32768, the target level is 0.
- R6: Cell k (k = 0..3) is at +1 (`cell_pos[k]`=1, `cell_neg[k]`=0) when level > k, at -1 (`cell_neg[k]`=1) when level < -k, and at 0 (both low) otherwise. The two outputs of a cell are never high together.
- R7: The reset angles are 1820, 4023, 7409 and 11250, which are 10, 22.1, 40.7 and 61.8 degrees.
- R8: An accepted write changes only the pending table. The active table takes the whole pending table on the clock where the accumulator carries out of bit 15, and it does not change otherwise.
- R9: A write to entry i is accepted only if 0 < angle <= 16384 and the angle lies strictly between pending entries i-1 and i+1 (where they exist). A refused write leaves the pending table as it was and raises `cfg_reject` for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_word | input | 16 | Phase increment per clock |
| cfg_we | input | 1 | Angle write strobe |
| cfg_idx | input | 2 | Angle entry index, 0 = smallest |
| cfg_angle | input | 16 | Angle value in phase units |
| cfg_reject | output | 1 | Pulses one cycle after a refused write |
| level | output | 4 | Signed staircase level, -4..+4 |
| cell_pos | output | 4 | Cell k drives +1 |
| cell_neg | output | 4 | Cell k drives -1 |

## Verification
The hardest case to set up is showing that an accepted angle write has no effect before the accumulator wraps. The bench makes this visible by steering the phase to a point that lies between the old and the new value of the top angle. It then holds the frequency word at zero so the phase cannot move, and confirms that the level does not change across the write. After that it lets the accumulator wrap, returns the phase to the same point, and confirms that the level drops. The exact fold points, the zero crossings and each angle boundary are reached by a one-unit-per-clock sweep over a whole turn, compared against an arithmetic model.

// File: rtl/she_staircase.sv
module she_staircase #(
  parameter int PW = 16,
  parameter int NC = 4,
  parameter logic [NC*PW-1:0] ANG_INIT = {16'd11250, 16'd7409, 16'd4023, 16'd1820},
  localparam int LW = $clog2(NC + 1) + 1,
  localparam int IW = $clog2(NC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-1:0]        freq_word,
  input  logic                 cfg_we,
  input  logic [IW-1:0]        cfg_idx,
  input  logic [PW-1:0]        cfg_angle,
  output logic                 cfg_reject,
  output logic signed [LW-1:0] level,
  output logic [NC-1:0]        cell_pos,
  output logic [NC-1:0]        cell_neg
);
  localparam int QTR = 1 << (PW - 2);

  logic [PW-1:0] phase, phase_nxt;
  logic          wrap;
  logic [PW-1:0] act [NC];
  logic [PW-1:0] sh  [NC];

  assign {wrap, phase_nxt} = {1'b0, phase} + {1'b0, freq_word};

  wire [PW-3:0] qoff = phase[PW-3:0];
  wire [PW-2:0] fold = phase[PW-2] ? (PW-1)'(QTR) - {1'b0, qoff} : {1'b0, qoff};

  logic [LW-1:0] cnt;
  always_comb begin
    cnt = '0;
    for (int i = 0; i < NC; i++)
      if ({1'b0, fold} >= act[i]) cnt = cnt + 1'b1;
  end

  logic signed [LW-1:0] target;
  assign target = phase[PW-1] ? -$signed(cnt) : $signed(cnt);

  logic [PW:0] lo, hi;
  always_comb begin
    lo = (cfg_idx == '0) ? '0 : {1'b0, sh[cfg_idx - 1'b1]};
    hi = (int'(cfg_idx) == NC - 1) ? (PW+1)'(QTR + 1) : {1'b0, sh[cfg_idx + 1'b1]};
  end
  wire ok = ({1'b0, cfg_angle} > lo) && ({1'b0, cfg_angle} < hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= '0;
      level      <= '0;
      cfg_reject <= 1'b0;
      for (int i = 0; i < NC; i++) begin
        act[i] <= ANG_INIT[i*PW +: PW];
        sh[i]  <= ANG_INIT[i*PW +: PW];
      end
    end else begin
      phase      <= phase_nxt;
      cfg_reject <= cfg_we && !ok;
      if (target > level)      level <= level + $signed(LW'(1));
      else if (target < level) level <= level - $signed(LW'(1));
      if (wrap) act <= sh;
      if (cfg_we && ok) sh[cfg_idx] <= cfg_angle;
    end
  end

  logic [NC*PW-1:0] act_flat;
  for (genvar k = 0; k < NC; k++) begin : g_cell
    assign cell_pos[k] = int'(level) > k;
    assign cell_neg[k] = int'(level) < -k;
    assign act_flat[k*PW +: PW] = act[k];
  end
endmodule

module she_staircase_chk #(
  parameter int PW = 16,
  parameter int NC = 4,
  parameter int LW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PW-1:0]        phase,
  input logic                 wrap,
  input logic                 cfg_we,
  input logic                 cfg_reject,
  input logic signed [LW-1:0] level,
  input logic signed [LW-1:0] target,
  input logic [NC-1:0]        cell_pos,
  input logic [NC-1:0]        cell_neg,
  input logic [NC*PW-1:0]     act_flat
);
  assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level == $past(level) || level == $past(level) + 1 || level == $past(level) - 1));

  assert_zero_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0 || phase == PW'(1 << (PW - 1))) |-> target == '0);

  assert_cell_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_pos & cell_neg) == '0);

  assert_cell_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cell_pos | cell_neg) == (level < 0 ? -int'(level) : int'(level)));

  assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_flat));

  assert_reject_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> !cfg_reject);
endmodule

bind she_staircase she_staircase_chk #(.PW(PW), .NC(NC), .LW(LW)) i_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .wrap(wrap), .cfg_we(cfg_we),
  .cfg_reject(cfg_reject), .level(level), .target(target),
  .cell_pos(cell_pos), .cell_neg(cell_neg), .act_flat(act_flat)
);

// File: tb/test_she_staircase.sv
module test_she_staircase;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] freq_word = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [15:0] cfg_angle = '0;
  logic cfg_reject;
  logic signed [3:0] level;
  logic [3:0] cell_pos, cell_neg;

  int vectors = 0;
  int errors = 0;
  int mphase, mlevel, mrej;
  int mact[4], msh[4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  she_staircase i_she_staircase (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_angle(cfg_angle), .cfg_reject(cfg_reject),
    .level(level), .cell_pos(cell_pos), .cell_neg(cell_neg)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (phase %0d)", req, act, exp, mphase);
    end
  endtask

  function automatic int tgt(input int p);
    int q, f, c;
    q = p % 32768;
    f = (q >= 16384) ? 32768 - q : q;
    c = 0;
    for (int i = 0; i < 4; i++) if (f >= mact[i]) c++;
    return (p >= 32768) ? -c : c;
  endfunction

  task automatic compare_all();
    int ep, en;
    check("R4 level", int'(level), mlevel);
    ep = 0; en = 0;
    for (int k = 0; k < 4; k++) begin
      if (mlevel > k) ep |= (1 << k);
      if (mlevel < -k) en |= (1 << k);
    end
    check("R6 cell_pos", int'(cell_pos), ep);
    check("R6 cell_neg", int'(cell_neg), en);
    check("R9 cfg_reject", int'(cfg_reject), mrej);
  endtask

  task automatic step(input int fw, input bit we, input int idx, input int ang);
    int t, sum, lo, hi;
    bit ok;
    freq_word = 16'(fw); cfg_we = we; cfg_idx = 2'(idx); cfg_angle = 16'(ang);
    t = tgt(mphase);
    if (t > mlevel) mlevel++; else if (t < mlevel) mlevel--;
    lo = (idx == 0) ? 0 : msh[idx - 1];
    hi = (idx == 3) ? 16385 : msh[idx + 1];
    ok = (ang > lo) && (ang < hi);
    mrej = (we && !ok) ? 1 : 0;
    sum = mphase + fw;
    if (sum >= 65536) for (int i = 0; i < 4; i++) mact[i] = msh[i];
    if (we && ok) msh[idx] = ang;
    mphase = sum % 65536;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    compare_all();
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int prev;
    mphase = 0; mlevel = 0; mrej = 0;
    mact = '{1820, 4023, 7409, 11250};
    msh = mact;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state (one idle clock with freq_word 0)
    check("R1 level", int'(level), 0);
    check("R1 cell_pos", int'(cell_pos), 0);
    check("R1 cell_neg", int'(cell_neg), 0);
    check("R1 cfg_reject", int'(cfg_reject), 0);

    // R2 R3 R5 R7: one full turn, one unit per clock
    for (int n = 0; n < 65536; n++) begin
      prev = mphase;
      step(1, 0, 0, 0);
      if (prev == 0 || prev == 32768) check("R5 zero at crossing", int'(level), 0);
      if (prev == 1819) check("R7 below first angle", int'(level), 0);
      if (prev == 1820) check("R7 first angle", int'(level), 1);
      if (prev == 11250) check("R7 last angle", int'(level), 4);
      if (prev == 16384) check("R3 quarter peak", int'(level), 4);
      if (prev == 49152) check("R3 negative peak", int'(level), -4);
    end

    // R4 slew under coarse steps
    for (int n = 0; n < 500; n++) step(300, 0, 0, 0);
    for (int n = 0; n < 60; n++) step(5000, 0, 0, 0);
    for (int n = 0; n < 40; n++) step(13107, 0, 0, 0);

    // R9 refused writes
    step(0, 1, 1, 1000);
    check("R9 below neighbour", int'(cfg_reject), 1);
    step(0, 1, 0, 0);
    check("R9 zero angle", int'(cfg_reject), 1);
    step(0, 1, 3, 20000);
    check("R9 beyond quarter", int'(cfg_reject), 1);
    step(0, 1, 2, 4023);
    check("R9 equal neighbour", int'(cfg_reject), 1);
    step(0, 0, 0, 0);
    check("R9 pulse one cycle", int'(cfg_reject), 0);

    // R8 pending write held back until wrap
    step((11500 - mphase + 65536) % 65536, 0, 0, 0);
    for (int n = 0; n < 10; n++) step(0, 0, 0, 0);
    check("R8 before write", int'(level), 4);
    step(0, 1, 3, 12000);
    check("R9 accepted", int'(cfg_reject), 0);
    for (int n = 0; n < 6; n++) step(0, 0, 0, 0);
    check("R8 no effect before wrap", int'(level), 4);
    for (int n = 0; n < 80; n++) step(1000, 0, 0, 0);
    step((11500 - mphase + 65536) % 65536, 0, 0, 0);
    for (int n = 0; n < 10; n++) step(0, 0, 0, 0);
    check("R8 effect after wrap", int'(level), 3);
    for (int n = 0; n < 700; n++) step(97, 0, 0, 0);

    finish_run();
  end
endmodule